// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two 8-bit bidirectional buses, called side A and side B. Each side owns a storage register with its own capture strobe. A direction input decides which side is driven and which one is read. A per-direction source select decides whether the driven side shows the live word from the opposite side or the word held in the opposite side's register. Every driven word is the bitwise complement of its source. An active-low enable turns off both drivers (isolation) and leaves capture untouched.

Each bus is split into an input vector, an output vector and an output-enable vector, so the block fits inside an FPGA fabric, with the pad buffers kept outside it. The two capture strobes are plain level inputs. A system clock samples them, and a register loads on the first clock edge at which its strobe is seen high after being low. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or data pin.

Top module: `xcvr_dual_register`

## Requirements
- R1: After reset both storage registers hold zero, so a driven side in stored mode shows all ones (8'hFF) before any capture.
- R2: The side-A register loads `a_in` on each clock edge where `cap_a` is sampled high and was sampled low at the previous edge.
- R3: The side-B register loads `b_in` on each clock edge where `cap_b` is sampled high and was sampled low at the previous edge.
- R4: When `oe_n` is 1, `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` are all zeros.
- R5: When `oe_n` is 0, `dir_ab`=1 makes `b_oe` all ones and `a_oe` all zeros, and `dir_ab`=0 does the reverse. An undriven side's output reads zero.
- R6: With `oe_n`=0, `dir_ab`=1 and `sel_ab`=0, `b_out` equals `~a_in` combinationally, in the same cycle.
- R7: With `oe_n`=0, `dir_ab`=1 and `sel_ab`=1, `b_out` equals the complement of the side-A register.
- R8: With `oe_n`=0 and `dir_ab`=0, `a_out` equals `~b_in` when `sel_ba`=0 and equals the complement of the side-B register when `sel_ba`=1.
- R9: Capture is never gated by `oe_n` or `dir_ab`. A word captured while isolated reads back correctly once stored mode is enabled.
- R10: A strobe held high loads only once. Later edges with the strobe still high leave the register unchanged even if the bus input changes.
- R11: In stored mode, the clock edge that loads a register also updates the opposite side's output immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 1 | Active-low output enable for both sides |
| dir_ab | input | 1 | 1: A feeds B (B driven); 0: B feeds A (A driven) |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B |
| cap_a | input | 1 | Capture strobe for the side-A register |
| cap_b | input | 1 | Capture strobe for the side-B register |
| a_in | input | 8 | Side-A bus as seen from the pad |
| a_out | output | 8 | Word driven onto side A |
| a_oe | output | 8 | Per-bit enable of the side-A driver |
| b_in | input | 8 | Side-B bus as seen from the pad |
| b_out | output | 8 | Word driven onto side B |
| b_oe | output | 8 | Per-bit enable of the side-B driver |

## Verification
Enables and transparent-mode outputs are combinational. They are due in the same cycle as the control or bus change that causes them. A register load, and a stored-mode output that depends on it, is due right after the first clock edge that sees a rising strobe. No further edge is involved. The bench changes every input on the falling edge and updates its own model at the rising edge. It compares all four outputs 1 ns after that rising edge, so a single sample covers both the combinational and the one-edge results.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] rise
);
  logic [N-1:0] strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_drive_sel.sv
module xcvr_drive_sel
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  src_e         src,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  logic [W-1:0] picked;

  always_comb begin
    picked = (src == SRC_STORED) ? stored : live;
    out    = en ? ~picked : '0;
    oe     = {W{en}};
  end
endmodule

// File: rtl/xcvr_dual_register.sv
module xcvr_dual_register
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir_ab,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  localparam int unsigned S = NUM_SIDES;

  logic [S-1:0]  rise;
  logic [W-1:0]  bus_in  [S];
  logic [W-1:0]  store   [S];
  logic [W-1:0]  drv_out [S];
  logic [W-1:0]  drv_oe  [S];
  logic [W-1:0]  store_a, store_b;

  assign bus_in[SIDE_A] = a_in;
  assign bus_in[SIDE_B] = b_in;

  xcvr_edge_detect #(.N(S)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe ({cap_b, cap_a}),
    .rise   (rise)
  );

  for (genvar k = 0; k < S; k++) begin : g_side
    localparam int unsigned OPP = S - 1 - k;
    logic en_k;
    src_e src_k;

    xcvr_store_reg #(.W(W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rise[k]),
      .d     (bus_in[k]),
      .q     (store[k])
    );

    if (k == int'(SIDE_B)) begin : g_b
      assign en_k  = !oe_n && dir_ab;
      assign src_k = src_e'(sel_ab);
    end else begin : g_a
      assign en_k  = !oe_n && !dir_ab;
      assign src_k = src_e'(sel_ba);
    end

    xcvr_drive_sel #(.W(W)) u_drive (
      .en     (en_k),
      .src    (src_k),
      .live   (bus_in[OPP]),
      .stored (store[OPP]),
      .out    (drv_out[k]),
      .oe     (drv_oe[k])
    );
  end

  assign store_a = store[SIDE_A];
  assign store_b = store[SIDE_B];
  assign a_out   = drv_out[SIDE_A];
  assign a_oe    = drv_oe[SIDE_A];
  assign b_out   = drv_out[SIDE_B];
  assign b_oe    = drv_oe[SIDE_B];
endmodule

// File: rtl/xcvr_dual_register_chk.sv
module xcvr_dual_register_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         oe_n,
  input logic         dir_ab,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_a,
  input logic         cap_b,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] store_a,
  input logic [W-1:0] store_b
);
  AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0)); // R4
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(|a_oe && |b_oe)); // R5
  AST_LIVE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir_ab && !sel_ab) |-> b_out == ~a_in); // R6
  AST_STORED_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && dir_ab && sel_ab) |-> b_out == ~store_a); // R7
  AST_STORED_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !dir_ab && sel_ba) |-> a_out == ~store_b); // R8
  AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_a) |=> store_a == $past(a_in)); // R2
  AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_b) |=> store_b == $past(b_in)); // R3
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cap_a) |=> $stable(store_a)); // R10
endmodule

bind xcvr_dual_register xcvr_dual_register_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .oe_n    (oe_n),
  .dir_ab  (dir_ab),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .cap_a   (cap_a),
  .cap_b   (cap_b),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .store_a (store_a),
  .store_b (store_b)
);

// File: tb/sim_xcvr_dual_register.sv
`timescale 1ns/1ps
module sim_xcvr_dual_register;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe_n = 1'b1, dir_ab = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_a = 1'b0, cap_b = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_a = '0, m_b = '0;
  logic prev_a = 1'b0, prev_b = 1'b0;

  always #5 clk = ~clk;

  xcvr_dual_register #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_ab(dir_ab),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] exp_b_out();
    if (oe_n || !dir_ab) return '0;
    return sel_ab ? ~m_a : ~a_in;
  endfunction

  function automatic logic [W-1:0] exp_a_out();
    if (oe_n || dir_ab) return '0;
    return sel_ba ? ~m_b : ~b_in;
  endfunction

  function automatic string tag_b();
    if (oe_n)   return "R4";
    if (!dir_ab) return "R5";
    return sel_ab ? "R7" : "R6";
  endfunction

  function automatic string tag_a();
    if (oe_n)  return "R4";
    if (dir_ab) return "R5";
    return "R8";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string note);
    check(tag_b(), {note, " b_out"}, b_out, exp_b_out());
    check(tag_a(), {note, " a_out"}, a_out, exp_a_out());
    check("R5", {note, " b_oe"}, b_oe, {W{!oe_n && dir_ab}});
    check("R5", {note, " a_oe"}, a_oe, {W{!oe_n && !dir_ab}});
  endtask

  task automatic step(input logic g, input logic d, input logic sab, input logic sba,
                      input logic ca, input logic cb,
                      input logic [W-1:0] ai, input logic [W-1:0] bi);
    @(negedge clk);
    oe_n = g; dir_ab = d; sel_ab = sab; sel_ba = sba;
    cap_a = ca; cap_b = cb; a_in = ai; b_in = bi;
    @(posedge clk);
    if (cap_a && !prev_a) m_a = a_in;
    if (cap_b && !prev_b) m_b = b_in;
    prev_a = cap_a;
    prev_b = cap_b;
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state seen through stored mode in both directions
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hC3);
    check("R1", "stored A after reset", b_out, 8'hFF);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3);
    check("R1", "stored B after reset", a_out, 8'hFF);

    // R4: isolation
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22);
    check_all("isolated");

    // R9: capture while isolated, then read back
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h96);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R9", "A captured while isolated", b_out, 8'hA5);
    check("R2", "A register via stored path", b_out, ~m_a);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R9", "B captured while isolated", a_out, 8'h69);
    check("R3", "B register via stored path", a_out, ~m_b);

    // R10: strobe held high loads once only
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h00);
    check("R11", "load edge updates B at once", b_out, 8'h7E);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF0, 8'h00);
    check("R10", "held strobe no reload", b_out, 8'h7E);

    // R11: B side, output follows the loading edge
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h4D);
    check("R11", "load edge updates A at once", a_out, 8'hB2);

    // R6 / R8 live paths
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE7, 8'h00);
    check("R6", "live A to B", b_out, 8'h18);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F);
    check("R8", "live B to A", a_out, 8'hF0);

    // random mix of all control combinations
    for (int i = 0; i < 800; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[0] & r[1], r[2], r[3], r[4], r[5], r[6],
           8'($urandom), 8'($urandom));
      check_all("random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule